// File: doc/BRIEF.md
# Four-Core MESI Coherence Controller with Last-Level Directory

This block keeps the private first-level caches of four cores coherent. Each core sends byte reads and byte writes on an 8-bit address. The controller accepts one request per clock. It looks up the requesting core's direct-mapped line, classifies the access, and updates the MESI state of that line in every core in the same cycle. One clock after acceptance it returns the byte to the requester.

Coherence bookkeeping lives in an untagged directory inside the shared last-level cache. The directory has one entry per 8-byte block of the address space, and each entry holds the latest clean copy of the line, a summary state and a sharer mask. The directory is only the backing store this block has. When a dirty line is read or written by another core, or is evicted, its data is written into the directory. Nothing goes to main memory.

A debug output shows, for each accepted request, the event class and the resulting state of the target line in all four cores.

Top module: `coh_mesi_dir_ctrl`

## Requirements
- R1: After reset every cache line and directory entry is Invalid with all data zero. The first read of any address returns 0x00 with event 2 and the requester in Exclusive.
- R2: Requests are accepted one per cycle by fixed priority, core 0 highest. `req_ready[i]` is high only in the cycle that core i's request is accepted. A lower core's request stays pending while a higher core is valid.
- R3: One cycle after acceptance, `rsp_valid` has exactly the accepted core's bit set for one cycle and `rsp_data` carries the byte: the read value, or the written value for a write. In the same cycle `dbg_valid` is high and `dbg_core` names the core.
- R4: A read miss with no other holder of the block fills the line from the directory. Event code is 2 and the requester becomes Exclusive.
- R5: A read miss where another core holds the block gives event code 1, and every holder plus the requester ends Shared. If a holder was Modified, its data is returned and also written into the directory.
- R6: A read hit gives event code 0 and changes no core's state.
- R7: A write hit gives event code 3 and leaves the writer Modified. From Shared it invalidates all other copies. From Exclusive or Modified no other core is involved.
- R8: A write miss gives event code 4 when other copies exist and event code 5 otherwise. The byte is merged into the most recent line, whether that comes from a Modified owner or from the directory. The writer ends Modified and all other copies end Invalid.
- R9: When a request replaces a line of a different tag, the old line is dropped from the directory's sharer mask. If that old line was Modified, its data is first written to its directory entry, so a later miss by any core returns it.
- R10: State encoding on `dbg_states` is Invalid=0, Shared=1, Exclusive=2, Modified=3, with core c in bits [2c+1:2c]. At most one core holds a line in Exclusive or Modified, and then no other core holds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 4 | Request valid, one bit per core |
| req_ready | output | 4 | Request accepted this cycle, one bit per core |
| req_write | input | 4 | 1 = write, 0 = read, per core |
| req_addr | input | 32 | Byte address per core, core c in bits [8c+7:8c] |
| req_wdata | input | 32 | Write byte per core, core c in bits [8c+7:8c] |
| rsp_valid | output | 4 | One-cycle response pulse to the accepted core |
| rsp_data | output | 8 | Byte returned with the response |
| dbg_valid | output | 1 | Debug record valid |
| dbg_core | output | 2 | Core whose request the record describes |
| dbg_event | output | 3 | Event class (0 read hit, 1 read miss shared, 2 read miss exclusive, 3 write hit, 4 write miss shared, 5 write miss exclusive) |
| dbg_states | output | 8 | Resulting state of the target line in every core |

## Verification
A single accepted request can drive both directory write ports in the same cycle. One port fills or flushes the target block, and the other retires the requester's displaced line, writing it back if it was Modified. The bench forces this case in two ways. First it lets a core dirty a block, then has it read a different tag at the same index while other cores share the target. Then it has a core whose Shared line at that index is displaced read the previously evicted block. The outcome is judged by the byte returned from the evicted block, together with the Shared states reported for the target, both computed from the requirements.

// File: rtl/coh_pkg.sv
package coh_pkg;

  // Line state encoding; the debug output exposes these codes.
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } st_e;

  // Event class of an accepted request.
  typedef enum logic [2:0] {
    EV_RD_HIT = 3'd0,
    EV_RD_SHR = 3'd1,
    EV_RD_EXC = 3'd2,
    EV_WR_HIT = 3'd3,
    EV_WR_SHR = 3'd4,
    EV_WR_EXC = 3'd5
  } ev_e;

endpackage

// File: rtl/coh_arbiter.sv
module coh_arbiter #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  valid,
  output logic [N-1:0]  gnt,
  output logic          any,
  output logic [IW-1:0] idx
);

  // Lowest index wins: scan from the top so the last hit is the lowest.
  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (valid[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
      end
    end
    any = |valid;
  end

endmodule

// File: rtl/coh_l1_bank.sv
module coh_l1_bank
  import coh_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 3,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [TAG_W-1:0]  rd_tag,
  output st_e               rd_state,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  st_e               wr_state,
  input  logic [LINE_W-1:0] wr_line
);

  localparam int SETS = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_q  [SETS];
  st_e               st_q   [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  assign rd_tag   = tag_q[rd_idx];
  assign rd_state = st_q[rd_idx];
  assign rd_line  = line_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        tag_q[s]  <= '0;
        st_q[s]   <= ST_I;
        line_q[s] <= '0;
      end
    end else if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      st_q[wr_idx]   <= wr_state;
      line_q[wr_idx] <= wr_line;
    end
  end

endmodule

// File: rtl/coh_dir.sv
module coh_dir
  import coh_pkg::*;
#(
  parameter int BLK_W  = 5,
  parameter int LINE_W = 64,
  parameter int N      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  // target block port
  input  logic [BLK_W-1:0]  a_blk,
  output logic [LINE_W-1:0] a_line,
  input  logic              a_we,
  input  logic [LINE_W-1:0] a_wline,
  input  st_e               a_wstate,
  input  logic [N-1:0]      a_wshare,
  // displaced block port
  input  logic [BLK_W-1:0]  b_blk,
  output logic [LINE_W-1:0] b_line,
  output st_e               b_state,
  output logic [N-1:0]      b_share,
  input  logic              b_we,
  input  logic [LINE_W-1:0] b_wline,
  input  st_e               b_wstate,
  input  logic [N-1:0]      b_wshare
);

  localparam int ENT = 1 << BLK_W;

  logic [LINE_W-1:0] line_q  [ENT];
  st_e               st_q    [ENT];
  logic [N-1:0]      share_q [ENT];

  assign a_line  = line_q[a_blk];
  assign b_line  = line_q[b_blk];
  assign b_state = st_q[b_blk];
  assign b_share = share_q[b_blk];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENT; e++) begin
        line_q[e]  <= '0;
        st_q[e]    <= ST_I;
        share_q[e] <= '0;
      end
    end else begin
      if (b_we) begin
        line_q[b_blk]  <= b_wline;
        st_q[b_blk]    <= b_wstate;
        share_q[b_blk] <= b_wshare;
      end
      if (a_we) begin
        line_q[a_blk]  <= a_wline;
        st_q[a_blk]    <= a_wstate;
        share_q[a_blk] <= a_wshare;
      end
    end
  end

  // R9: the displaced block and the target block never collide in one cycle
  a_r9_ports_apart: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we && b_we) |-> (a_blk != b_blk));

endmodule

// File: rtl/coh_mesi_dir_ctrl.sv
module coh_mesi_dir_ctrl
  import coh_pkg::*;
#(
  parameter int NCORE  = 4,
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCORE-1:0]         req_valid,
  output logic [NCORE-1:0]         req_ready,
  input  logic [NCORE-1:0]         req_write,
  input  logic [NCORE*ADDR_W-1:0]  req_addr,
  input  logic [NCORE*DATA_W-1:0]  req_wdata,
  output logic [NCORE-1:0]         rsp_valid,
  output logic [DATA_W-1:0]        rsp_data,
  output logic                     dbg_valid,
  output logic [$clog2(NCORE)-1:0] dbg_core,
  output logic [2:0]               dbg_event,
  output logic [2*NCORE-1:0]       dbg_states
);

  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int LINE_B = 1 << OFF_W;
  localparam int LINE_W = LINE_B * DATA_W;
  localparam int CID_W  = $clog2(NCORE);

  // ---------------- reset release synchroniser ----------------
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // ---------------- arbitration ----------------
  logic [NCORE-1:0] arb_in, gnt;
  logic             gnt_any;
  logic [CID_W-1:0] g;

  assign arb_in = req_valid & {NCORE{rst_i_n}};

  coh_arbiter #(.N(NCORE), .IW(CID_W)) u_arb (
    .valid (arb_in),
    .gnt   (gnt),
    .any   (gnt_any),
    .idx   (g)
  );
  assign req_ready = gnt;

  // ---------------- selected request fields ----------------
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wdata;
  logic              sel_we;
  logic [TAG_W-1:0]  tag;
  logic [IDX_W-1:0]  idx;
  logic [OFF_W-1:0]  off;
  logic [BLK_W-1:0]  blk;

  always_comb begin
    sel_addr  = req_addr[g*ADDR_W +: ADDR_W];
    sel_wdata = req_wdata[g*DATA_W +: DATA_W];
    sel_we    = req_write[g];
    tag       = sel_addr[ADDR_W-1 -: TAG_W];
    idx       = sel_addr[OFF_W +: IDX_W];
    off       = sel_addr[OFF_W-1:0];
    blk       = sel_addr[ADDR_W-1:OFF_W];
  end

  // ---------------- private caches ----------------
  logic [TAG_W-1:0]  l1_tag   [NCORE];
  st_e               l1_st    [NCORE];
  logic [LINE_W-1:0] l1_line  [NCORE];
  logic [LINE_W-1:0] l1_wline [NCORE];
  st_e               nst      [NCORE];
  logic [NCORE-1:0]  l1_we;

  for (genvar c = 0; c < NCORE; c++) begin : g_l1
    coh_l1_bank #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .rd_idx   (idx),
      .rd_tag   (l1_tag[c]),
      .rd_state (l1_st[c]),
      .rd_line  (l1_line[c]),
      .wr_en    (l1_we[c]),
      .wr_idx   (idx),
      .wr_tag   (tag),
      .wr_state (nst[c]),
      .wr_line  (l1_wline[c])
    );
  end

  // ---------------- directory ----------------
  logic [LINE_W-1:0] dir_a_line, dir_b_line;
  st_e               dir_b_state;
  logic [NCORE-1:0]  dir_b_share;
  logic [LINE_W-1:0] da_line, db_line;
  st_e               da_st, db_st;
  logic [NCORE-1:0]  da_share, db_share;
  logic              vic_we;
  logic [BLK_W-1:0]  vic_blk;

  coh_dir #(.BLK_W(BLK_W), .LINE_W(LINE_W), .N(NCORE)) u_dir (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .a_blk    (blk),
    .a_line   (dir_a_line),
    .a_we     (gnt_any),
    .a_wline  (da_line),
    .a_wstate (da_st),
    .a_wshare (da_share),
    .b_blk    (vic_blk),
    .b_line   (dir_b_line),
    .b_state  (dir_b_state),
    .b_share  (dir_b_share),
    .b_we     (vic_we),
    .b_wline  (db_line),
    .b_wstate (db_st),
    .b_wshare (db_share)
  );

  // ---------------- classification and next line states ----------------
  logic [NCORE-1:0]  holds, oth;
  logic              own_m, hit;
  logic [LINE_W-1:0] own_line, base_line, new_line;
  st_e               rq_st;
  ev_e               ev;
  logic [DATA_W-1:0] rd_byte;

  always_comb begin
    holds    = '0;
    oth      = '0;
    own_m    = 1'b0;
    own_line = '0;
    for (int c = 0; c < NCORE; c++) begin
      holds[c] = (l1_st[c] != ST_I) && (l1_tag[c] == tag);
      if ((CID_W'(c) != g) && holds[c]) begin
        oth[c] = 1'b1;
        if (l1_st[c] == ST_M) begin
          own_m    = 1'b1;
          own_line = l1_line[c];
        end
      end
    end
    hit   = holds[g];
    rq_st = l1_st[g];

    // freshest copy: own line, else a dirty owner, else the directory
    base_line = hit ? l1_line[g] : (own_m ? own_line : dir_a_line);
    new_line  = base_line;
    if (sel_we) new_line[off*DATA_W +: DATA_W] = sel_wdata;
    rd_byte = new_line[off*DATA_W +: DATA_W];

    for (int c = 0; c < NCORE; c++) nst[c] = holds[c] ? l1_st[c] : ST_I;

    ev = EV_RD_HIT;
    if (!sel_we) begin
      if (hit) begin
        ev = EV_RD_HIT;
      end else if (|oth) begin
        ev = EV_RD_SHR;
        for (int c = 0; c < NCORE; c++) if (holds[c]) nst[c] = ST_S;
        nst[g] = ST_S;
      end else begin
        ev     = EV_RD_EXC;
        nst[g] = ST_E;
      end
    end else begin
      if (hit)       ev = EV_WR_HIT;
      else if (|oth) ev = EV_WR_SHR;
      else           ev = EV_WR_EXC;
      for (int c = 0; c < NCORE; c++) nst[c] = ST_I;
      nst[g] = ST_M;
    end

    for (int c = 0; c < NCORE; c++) begin
      l1_we[c]    = gnt_any && ((CID_W'(c) == g) || holds[c]);
      l1_wline[c] = (CID_W'(c) == g) ? new_line : l1_line[c];
    end
  end

  // ---------------- directory update values ----------------
  logic any_m, any_e, any_s;

  always_comb begin
    da_share = '0;
    any_m    = 1'b0;
    any_e    = 1'b0;
    any_s    = 1'b0;
    for (int c = 0; c < NCORE; c++) begin
      da_share[c] = (nst[c] != ST_I);
      if (nst[c] == ST_M) any_m = 1'b1;
      if (nst[c] == ST_E) any_e = 1'b1;
      if (nst[c] == ST_S) any_s = 1'b1;
    end
    if (any_m)      da_st = ST_M;
    else if (any_e) da_st = ST_E;
    else if (any_s) da_st = ST_S;
    else            da_st = ST_I;
    // dirty owner data lands in the directory, never in main memory
    da_line = own_m ? own_line : dir_a_line;

    // displaced line of a different tag in the requester's slot
    vic_we   = gnt_any && !hit && (rq_st != ST_I);
    vic_blk  = {l1_tag[g], idx};
    db_line  = (rq_st == ST_M) ? l1_line[g] : dir_b_line;
    db_share = dir_b_share & ~gnt;
    db_st    = (db_share == '0) ? ST_I : dir_b_state;
  end

  // ---------------- response and debug registers ----------------
  logic [NCORE-1:0]   rsp_valid_n;
  logic [DATA_W-1:0]  rsp_data_n;
  logic               dbg_valid_n;
  logic [CID_W-1:0]   dbg_core_n;
  logic [2:0]         dbg_event_n;
  logic [2*NCORE-1:0] dbg_states_n;

  always_comb begin
    rsp_valid_n  = gnt;
    dbg_valid_n  = gnt_any;
    rsp_data_n   = rsp_data;
    dbg_core_n   = dbg_core;
    dbg_event_n  = dbg_event;
    dbg_states_n = dbg_states;
    if (gnt_any) begin
      rsp_data_n  = rd_byte;
      dbg_core_n  = g;
      dbg_event_n = ev;
      for (int c = 0; c < NCORE; c++) dbg_states_n[2*c +: 2] = nst[c];
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rsp_valid  <= '0;
      rsp_data   <= '0;
      dbg_valid  <= 1'b0;
      dbg_core   <= '0;
      dbg_event  <= '0;
      dbg_states <= '0;
    end else begin
      rsp_valid  <= rsp_valid_n;
      rsp_data   <= rsp_data_n;
      dbg_valid  <= dbg_valid_n;
      dbg_core   <= dbg_core_n;
      dbg_event  <= dbg_event_n;
      dbg_states <= dbg_states_n;
    end
  end

  // ---------------- assertions ----------------
  logic [CID_W:0] chk_held, chk_excl;
  logic [1:0]     chk_req_st;

  always_comb begin
    chk_held = '0;
    chk_excl = '0;
    for (int c = 0; c < NCORE; c++) begin
      if (dbg_states[2*c +: 2] != 2'd0) chk_held = chk_held + 1'b1;
      if (dbg_states[2*c +: 2] >= 2'd2) chk_excl = chk_excl + 1'b1;
    end
    chk_req_st = dbg_states[dbg_core*2 +: 2];
  end

  // R2: at most one acceptance per cycle
  a_r2_single_accept: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(req_ready));

  // R2: core 0 is never held off
  a_r2_core0_first: assert property (@(posedge clk) disable iff (!rst_i_n)
    req_valid[0] |-> req_ready[0]);

  // R3: the response pulse follows the acceptance by one cycle
  a_r3_rsp_follows: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|req_ready) |=> (dbg_valid && (rsp_valid == $past(req_ready))));

  // R8: every write leaves the writer Modified
  a_r8_writer_owns: assert property (@(posedge clk) disable iff (!rst_i_n)
    (dbg_valid && (dbg_event >= 3'd3)) |-> (chk_req_st == 2'd3));

  // R10: an exclusive or dirty holder is the only holder
  a_r10_lone_owner: assert property (@(posedge clk) disable iff (!rst_i_n)
    dbg_valid |-> ((chk_excl == '0) || (chk_held == 1)));

endmodule

// File: tb/coh_mesi_dir_ctrl_tb.sv
module coh_mesi_dir_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic [3:0]  req_valid;
  logic [3:0]  req_ready;
  logic [3:0]  req_write;
  logic [31:0] req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  rsp_valid;
  logic [7:0]  rsp_data;
  logic        dbg_valid;
  logic [1:0]  dbg_core;
  logic [2:0]  dbg_event;
  logic [7:0]  dbg_states;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  coh_mesi_dir_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .dbg_valid  (dbg_valid),
    .dbg_core   (dbg_core),
    .dbg_event  (dbg_event),
    .dbg_states (dbg_states)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // fields: req, core, write, addr, wdata, exp data, exp event, exp states
  localparam int NV = 18;
  localparam logic [63:0] VEC [NV] = '{
    {8'd8, 8'd0, 8'd1, 8'h40, 8'h14, 8'h14, 8'd5, 8'h03}, // R8 miss, no copies
    {8'd8, 8'd2, 8'd1, 8'h44, 8'h07, 8'h07, 8'd4, 8'h30}, // R8 merge into dirty owner
    {8'd5, 8'd1, 8'd0, 8'h40, 8'h00, 8'h14, 8'd1, 8'h14}, // R5 dirty owner supplies
    {8'd6, 8'd1, 8'd0, 8'h44, 8'h00, 8'h07, 8'd0, 8'h14}, // R6
    {8'd7, 8'd1, 8'd1, 8'h46, 8'h4D, 8'h4D, 8'd3, 8'h0C}, // R7 from Shared
    {8'd7, 8'd1, 8'd1, 8'h47, 8'h01, 8'h01, 8'd3, 8'h0C}, // R7 on Modified
    {8'd5, 8'd3, 8'd0, 8'h46, 8'h00, 8'h4D, 8'd1, 8'h44}, // R5
    {8'd5, 8'd0, 8'd0, 8'h41, 8'h00, 8'h00, 8'd1, 8'h45}, // R5 three sharers
    {8'd6, 8'd0, 8'd0, 8'h47, 8'h00, 8'h01, 8'd0, 8'h45}, // R6
    {8'd4, 8'd2, 8'd0, 8'h80, 8'h00, 8'h00, 8'd2, 8'h20}, // R4
    {8'd7, 8'd2, 8'd1, 8'h81, 8'h5A, 8'h5A, 8'd3, 8'h30}, // R7 silent from Exclusive
    {8'd9, 8'd2, 8'd0, 8'h42, 8'h00, 8'h00, 8'd1, 8'h55}, // R9 dirty line displaced
    {8'd9, 8'd3, 8'd0, 8'h81, 8'h00, 8'h5A, 8'd2, 8'h80}, // R9 evicted data returns
    {8'd7, 8'd1, 8'd1, 8'h40, 8'h99, 8'h99, 8'd3, 8'h0C}, // R7 invalidates two
    {8'd5, 8'd0, 8'd0, 8'h40, 8'h00, 8'h99, 8'd1, 8'h05}, // R5
    {8'd7, 8'd3, 8'd1, 8'h82, 8'h11, 8'h11, 8'd3, 8'hC0}, // R7
    {8'd5, 8'd2, 8'd0, 8'h40, 8'h00, 8'h99, 8'd1, 8'h15}, // R5 directory holds flushed data
    {8'd9, 8'd0, 8'd0, 8'h82, 8'h00, 8'h11, 8'd1, 8'h41}  // R9 Shared line displaced
  };

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    req_valid = '0;
    req_write = '0;
    req_addr  = '0;
    req_wdata = '0;
    rst_n     = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // issue one request and check the registered result one cycle later
  task automatic run(input int rq, input int c, input bit we, input logic [7:0] a,
                     input logic [7:0] d, input logic [7:0] xd, input logic [2:0] xev,
                     input logic [7:0] xst);
    string r;
    r = $sformatf("R%0d", rq);
    @(negedge clk);
    req_valid = '0;
    req_valid[c] = 1'b1;
    req_write[c] = we;
    req_addr[c*8 +: 8]  = a;
    req_wdata[c*8 +: 8] = d;
    @(negedge clk);
    req_valid = '0;
    check_eq({r, " data"},  rsp_data, xd);
    check_eq({r, " event"}, dbg_event, xev);
    check_eq({r, "/R10 states"}, dbg_states, xst);
    check_eq("R3 rsp_valid", rsp_valid, 32'(4'b1 << c));
    check_eq("R3 dbg_core",  dbg_core, c);
  endtask

  initial begin
    do_reset();
    // R1: idle after reset
    check_eq("R1 rsp_valid idle", rsp_valid, 0);
    check_eq("R1 dbg_valid idle", dbg_valid, 0);
    check_eq("R2 ready idle", req_ready, 0);
    // R1: first read sees zero data and gets Exclusive
    run(1, 1, 1'b0, 8'h40, 8'h00, 8'h00, 3'd2, 8'h08);
    run(1, 1, 1'b0, 8'h45, 8'h00, 8'h00, 3'd0, 8'h08);
    // R3: the response is a single pulse
    @(negedge clk);
    check_eq("R3 pulse ends", rsp_valid, 0);
    check_eq("R3 dbg ends", dbg_valid, 0);

    do_reset();
    for (int i = 0; i < NV; i++) begin
      run(int'(VEC[i][63:56]), int'(VEC[i][55:48]), VEC[i][40], VEC[i][39:32],
          VEC[i][31:24], VEC[i][23:16], VEC[i][10:8], VEC[i][7:0]);
    end

    // R2: all four cores request at once; service order 0,1,2,3
    do_reset();
    @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      req_valid[c] = 1'b1;
      req_write[c] = 1'b0;
      req_addr[c*8 +: 8] = 8'(c * 8);
    end
    #1;
    check_eq("R2 first grant", req_ready, 32'h1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check_eq("R2 order", dbg_core, k);
      check_eq("R3 rsp owner", rsp_valid, 32'(4'b1 << k));
      check_eq("R4 lone reader", dbg_states, 32'(8'h2 << (2 * k)));
      req_valid[k] = 1'b0;
      #1;
      if (k < 3) check_eq("R2 next grant", req_ready, 32'(4'b1 << (k + 1)));
    end
    @(negedge clk);
    check_eq("R2 drained", rsp_valid, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule